// File: doc/BRIEF.md
# Class-Partitioned 64-bit ALU

This block is a purely combinational arithmetic-logic unit for 64-bit operands `a` and `b`, steered by a 4-bit operation code `op` and producing a 64-bit result `r`. Its thirteen operations fall into four classes: bitwise logic, add/subtract, set-on-less-than, and shifts. Four class units run side by side on every input. A final bus multiplexer, steered by the two upper opcode bits, forwards one class result to `r`.

The less-than unit never compares the operands itself. It sees only the two operand sign bits, the sign bit of the adder output and the adder carry-out. Whenever a comparison is selected, the adder is forced to compute `a - b`. Overflow traps and zero flags are not part of this block. It is meant to sit between operand registers and a result register in a datapath, and it adds no pipeline stage.

Top module: `class_alu`

## Requirements
- R1: `op[3:2]` selects the class that drives `r`: 00 logic, 01 add/subtract, 10 compare, 11 shift. `op[1:0]` selects the operation within that class.
- R2: Logic class: `op[1:0]` = 00 gives a AND b, 01 gives a OR b, 10 gives NOT(a OR b), 11 gives a XOR b.
- R3: Add/subtract class: codes 0100 and 0101 give (a + b) mod 2^64. Codes 0110 and 0111 give (a - b) mod 2^64. No overflow is signalled.
- R4: Code 1000 sets `r` to 1 when a < b as two's-complement signed values and to 0 otherwise. This includes operand pairs whose difference overflows.
- R5: Code 1001 sets `r` to 1 when a < b as unsigned values and to 0 otherwise.
- R6: Every compare result has bits 63 to 1 equal to zero.
- R7: Code 1100 gives a shifted left by `b[5:0]`, with zeros filled in. Bits 63 to 6 of `b` have no effect.
- R8: Code 1101 gives a shifted right by `b[5:0]`, with zeros filled in. Bits 63 to 6 of `b` have no effect.
- R9: Code 1110 gives a shifted right by `b[5:0]`, with copies of `a[63]` filled in.
- R10: The unused codes 1010, 1011 and 1111 give `r` equal to all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand; the value that is shifted in the shift class |
| b | input | 64 | Second operand; bits 5:0 give the shift distance |
| op | input | 4 | Operation code: class in bits 3:2, function in bits 1:0 |
| r | output | 64 | Selected result |

## Verification
The bench goes after signed comparisons across a sign boundary, such as the most negative value against the most positive. Here the subtractor overflows, so a design that trusted only the difference's sign would return the inverted answer. Unsigned compares of values with the top bit set catch a design that inverts the carry sense or mixes up SLT and SLTU. Shift distances of 0, 1, 63 and beyond 63 through the upper bits of `b` expose barrel-stage fill errors, a missing sign fill on arithmetic right shifts, and leakage of `b[63:6]` into the distance. Sweeping every opcode, including the three unused codes, catches a class multiplexer that selects on the wrong bits or returns stale class output on an unused code.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OP_W  = 4;
    localparam int FN_W  = 2;
    localparam int CLS_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_LOGIC = 2'b00,
        CLS_ARITH = 2'b01,
        CLS_CMP   = 2'b10,
        CLS_SHIFT = 2'b11
    } op_class_e;

    typedef enum logic [FN_W-1:0] {
        LF_AND = 2'b00,
        LF_OR  = 2'b01,
        LF_NOR = 2'b10,
        LF_XOR = 2'b11
    } logic_fn_e;

    typedef enum logic [FN_W-1:0] {
        AF_ADD  = 2'b00,
        AF_ADDU = 2'b01,
        AF_SUB  = 2'b10,
        AF_SUBU = 2'b11
    } arith_fn_e;

    typedef enum logic [FN_W-1:0] {
        CF_SLT  = 2'b00,
        CF_SLTU = 2'b01,
        CF_RSV0 = 2'b10,
        CF_RSV1 = 2'b11
    } cmp_fn_e;

    typedef enum logic [FN_W-1:0] {
        SF_SLL = 2'b00,
        SF_SRL = 2'b01,
        SF_SRA = 2'b10,
        SF_RSV = 2'b11
    } shift_fn_e;

    typedef struct packed {
        op_class_e        cls;
        logic [FN_W-1:0]  fn;
    } opcode_t;

    // Everything the less-than unit is allowed to see.
    typedef struct packed {
        logic a_sign;
        logic b_sign;
        logic d_sign;
        logic carry;
    } cmp_flags_t;

    // The adder subtracts for SUB/SUBU and for every compare code.
    function automatic logic needs_subtract(opcode_t o);
        return (o.cls == CLS_CMP) || ((o.cls == CLS_ARITH) && o.fn[1]);
    endfunction

    function automatic opcode_t split_op(logic [OP_W-1:0] raw);
        opcode_t o;
        o.cls = op_class_e'(raw[OP_W-1 -: CLS_W]);
        o.fn  = raw[FN_W-1:0];
        return o;
    endfunction

endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [FN_W-1:0]  fn,
    output logic [WIDTH-1:0] y
);

    logic_fn_e sel;
    assign sel = logic_fn_e'(fn);

    always_comb begin
        unique case (sel)
            LF_AND:  y = a & b;
            LF_OR:   y = a | b;
            LF_NOR:  y = ~(a | b);
            LF_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             do_sub,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    logic [WIDTH-1:0] b_eff;
    logic [WIDTH:0]   full;

    // Subtraction as a + ~b + 1; carry-out high means no borrow.
    assign b_eff = do_sub ? ~b : b;
    assign full  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, do_sub};

    assign sum       = full[WIDTH-1:0];
    assign carry_out = full[WIDTH];

endmodule

// File: rtl/alu_cmp_unit.sv
module alu_cmp_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  cmp_flags_t       flags,
    input  logic [FN_W-1:0]  fn,
    output logic [WIDTH-1:0] y
);

    cmp_fn_e sel;
    logic    lt;

    assign sel = cmp_fn_e'(fn);

    always_comb begin
        unique case (sel)
            // Differing signs: the negative operand is smaller and the
            // difference may have overflowed, so trust a's sign.
            CF_SLT:  lt = (flags.a_sign ^ flags.b_sign) ? flags.a_sign : flags.d_sign;
            CF_SLTU: lt = ~flags.carry;
            default: lt = 1'b0;
        endcase
    end

    assign y = {{(WIDTH-1){1'b0}}, lt};

endmodule

// File: rtl/alu_shift_unit.sv
module alu_shift_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 64,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [SHW-1:0]   amt,
    input  logic [FN_W-1:0]  fn,
    output logic [WIDTH-1:0] y
);

    shift_fn_e        sel;
    logic             go_left;
    logic             fill;
    logic [WIDTH-1:0] a_rev;
    logic [WIDTH-1:0] out_rev;
    logic [WIDTH-1:0] stage [0:SHW];

    assign sel     = shift_fn_e'(fn);
    assign go_left = (sel == SF_SLL);
    assign fill    = (sel == SF_SRA) & a[WIDTH-1];

    // Left shifts reuse the right-shifting network on bit-reversed data.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev_in
        assign a_rev[i] = a[WIDTH-1-i];
    end

    assign stage[0] = go_left ? a_rev : a;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign stage[k+1] = amt[k] ? {{DIST{fill}}, stage[k][WIDTH-1:DIST]}
                                   : stage[k];
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_rev_out
        assign out_rev[i] = stage[SHW][WIDTH-1-i];
    end

    always_comb begin
        unique case (sel)
            SF_SLL:  y = out_rev;
            SF_SRL,
            SF_SRA:  y = stage[SHW];
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/class_alu.sv
module class_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [OP_W-1:0]  op,
    output logic [WIDTH-1:0] r
);

    localparam int SHW = $clog2(WIDTH);

    opcode_t          opc;
    logic             sub_en;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] arith_y;
    logic [WIDTH-1:0] cmp_y;
    logic [WIDTH-1:0] shift_y;
    logic             arith_c;
    cmp_flags_t       flags;

    assign opc    = split_op(op);
    assign sub_en = needs_subtract(opc);

    alu_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a  (a),
        .b  (b),
        .fn (opc.fn),
        .y  (logic_y)
    );

    alu_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .a         (a),
        .b         (b),
        .do_sub    (sub_en),
        .sum       (arith_y),
        .carry_out (arith_c)
    );

    assign flags.a_sign = a[WIDTH-1];
    assign flags.b_sign = b[WIDTH-1];
    assign flags.d_sign = arith_y[WIDTH-1];
    assign flags.carry  = arith_c;

    alu_cmp_unit #(.WIDTH(WIDTH)) u_cmp (
        .flags (flags),
        .fn    (opc.fn),
        .y     (cmp_y)
    );

    alu_shift_unit #(.WIDTH(WIDTH)) u_shift (
        .a   (a),
        .amt (b[SHW-1:0]),
        .fn  (opc.fn),
        .y   (shift_y)
    );

    // Class multiplexer on the upper opcode bits.
    always_comb begin
        unique case (opc.cls)
            CLS_LOGIC: r = logic_y;
            CLS_ARITH: r = arith_y;
            CLS_CMP:   r = cmp_y;
            CLS_SHIFT: r = shift_y;
            default:   r = '0;
        endcase
    end

endmodule

// File: rtl/class_alu_checker.sv
module class_alu_checker #(
    parameter int WIDTH = 64
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic [3:0]       op,
    input logic [WIDTH-1:0] r
);

    localparam int SHW = $clog2(WIDTH);

    always_comb begin
        if (op == 4'b0100 || op == 4'b0101) begin
            a_r3_add_sum: assert (r == a + b)
                else $error("a_r3_add_sum violated");
        end
        if (op == 4'b1000) begin
            a_r4_slt_signed: assert (r[0] == ($signed(a) < $signed(b)))
                else $error("a_r4_slt_signed violated");
        end
        if (op == 4'b1001) begin
            a_r5_sltu_unsigned: assert (r[0] == (a < b))
                else $error("a_r5_sltu_unsigned violated");
        end
        if (op[3:2] == 2'b10) begin
            a_r6_cmp_upper_zero: assert (r[WIDTH-1:1] == '0)
                else $error("a_r6_cmp_upper_zero violated");
        end
        if (op == 4'b1110) begin
            a_r9_sra_fill: assert (r == WIDTH'($signed(a) >>> b[SHW-1:0]))
                else $error("a_r9_sra_fill violated");
        end
        if (op == 4'b1010 || op == 4'b1011 || op == 4'b1111) begin
            a_r10_unused_zero: assert (r == '0)
                else $error("a_r10_unused_zero violated");
        end
    end

endmodule

bind class_alu class_alu_checker #(.WIDTH(WIDTH)) u_chk (
    .a  (a),
    .b  (b),
    .op (op),
    .r  (r)
);

// File: tb/tb_class_alu.sv
module tb_class_alu;

    localparam int CLK_PERIOD = 10;
    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [3:0]   op_i = 4'b0000;
    logic [W-1:0] r_o;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    class_alu #(.WIDTH(W)) dut (
        .a  (a_i),
        .b  (b_i),
        .op (op_i),
        .r  (r_o)
    );

    function automatic logic [W-1:0] model(logic [W-1:0] x, logic [W-1:0] y, logic [3:0] o);
        logic [5:0] s;
        s = y[5:0];
        case (o)
            4'b0000: return x & y;
            4'b0001: return x | y;
            4'b0010: return ~(x | y);
            4'b0011: return x ^ y;
            4'b0100, 4'b0101: return x + y;
            4'b0110, 4'b0111: return x - y;
            4'b1000: return {63'd0, ($signed(x) < $signed(y))};
            4'b1001: return {63'd0, (x < y)};
            4'b1100: return x << s;
            4'b1101: return x >> s;
            4'b1110: return W'($signed(x) >>> s);
            default: return '0;
        endcase
    endfunction

    function automatic string req_of(logic [3:0] o);
        case (o)
            4'b0000, 4'b0001, 4'b0010, 4'b0011: return "R1/R2";
            4'b0100, 4'b0101, 4'b0110, 4'b0111: return "R1/R3";
            4'b1000: return "R1/R4/R6";
            4'b1001: return "R1/R5/R6";
            4'b1100: return "R1/R7";
            4'b1101: return "R1/R8";
            4'b1110: return "R1/R9";
            default: return "R1/R10";
        endcase
    endfunction

    task automatic check_one(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic [3:0] to);
        logic [W-1:0] exp;
        a_i  = ta;
        b_i  = tb;
        op_i = to;
        @(negedge clk);
        exp = model(ta, tb, to);
        n_cmp++;
        if (r_o !== exp) begin
            n_bad++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h",
                     req_of(to), to, ta, tb, r_o, exp);
        end
        @(posedge clk);
    endtask

    logic [W-1:0] corners [12];

    initial begin
        logic [W-1:0] lcg_a;
        logic [W-1:0] lcg_b;
        corners[0]  = 64'h0000_0000_0000_0000;
        corners[1]  = 64'h0000_0000_0000_0001;
        corners[2]  = 64'hFFFF_FFFF_FFFF_FFFF;
        corners[3]  = 64'h7FFF_FFFF_FFFF_FFFF;
        corners[4]  = 64'h8000_0000_0000_0000;
        corners[5]  = 64'h8000_0000_0000_0001;
        corners[6]  = 64'h0000_0000_0000_003F;
        corners[7]  = 64'hFFFF_FFFF_FFFF_FFC1;  // shift distance 1 with upper bits set (R7, R8)
        corners[8]  = 64'h0000_0000_0000_0040;  // distance 0 with bit 6 set
        corners[9]  = 64'hDEAD_BEEF_0123_4567;
        corners[10] = 64'h5555_AAAA_3C3C_C3A0;
        corners[11] = 64'h0000_0000_0000_0020;

        // Idle state after reset: zero operands, AND code, zero result (R2).
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_cmp++;
        if (r_o !== '0) begin
            n_bad++;
            $display("FAIL R2 reset state actual=%h expected=%h", r_o, 64'd0);
        end
        rst = 1'b0;
        @(posedge clk);

        // Corner sweep over every opcode, unused codes included (R1..R10).
        for (int i = 0; i < 12; i++)
            for (int j = 0; j < 12; j++)
                for (int o = 0; o < 16; o++)
                    check_one(corners[i], corners[j], 4'(o));

        // Pseudo-random operands over every opcode.
        lcg_a = 64'h1234_5678_9ABC_DEF0;
        lcg_b = 64'h0FED_CBA9_8765_4321;
        for (int n = 0; n < 1000; n++) begin
            lcg_a = lcg_a * 64'd6364136223846793005 + 64'd1442695040888963407;
            lcg_b = lcg_b * 64'd2862933555777941757 + 64'd3037000493;
            for (int o = 0; o < 16; o++)
                check_one(lcg_a, (n % 4 == 0) ? lcg_a ^ 64'h1 : lcg_b, 4'(o));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule